// File: doc/BRIEF.md
# Hardwired Step-Sequenced Processor Controller

This block is the hardwired control unit of a small 32-bit processor built around one internal bus. A step counter walks through the timing steps of each instruction. The controller decodes the 4-bit opcode held in the instruction register. It combines the current step, the decoded instruction and the zero and minus flags, and from these it drives every enable the datapath needs. These are the bus-drive and register-load strobes, the ALU operation, the constant-4 versus Y operand select, memory read and write, and the wait-for-memory request. It also raises a completion strobe in the last step of each instruction.

Every instruction starts with the same three fetch steps. Each opcode then runs its own fixed execute sequence, which is one to three steps long. Conditional branches whose flag test fails finish at step 4. While a memory wait is requested, the step counter holds until the memory reports completion. The completion strobe returns the counter to step 1 at the next clock edge, provided the counter is not held in the same cycle.

Top module: `ctl_hardwired`

## Requirements
- R1: A synchronous active-high reset puts the step counter at step 1. In the first cycle after reset the outputs are the step-1 fetch set: pc_drv, mar_ld, rd, k4_sel and z_ld high, with alu_op = 1 (add).
- R2: The fetch runs in three steps. Step 1 is as in R1. Step 2 drives z_drv, pc_ld, y_ld, wait_mem and mdr_ld_ext. Step 3 drives mdr_drv and ir_ld. Every other output is 0 and alu_op is 0 (idle) in steps 2 and 3.
- R3: When wait_mem is high and mem_done is low, the step does not change at the clock edge, so the same outputs repeat in the next cycle.
- R4: The register-pair ALU opcodes are 0 (add), 1 (subtract), 2 (and) and 3 (or). Step 4 drives ry_drv and y_ld. Step 5 drives rx_drv, z_ld and alu_op. alu_op is 1, 2, 3 or 4 for the four opcodes, and k4_sel stays low. Step 6 drives z_drv, ry_ld and done.
- R5: Opcode 6 is the indirect load. Step 4 drives rx_drv, mar_ld and rd. Step 5 drives mdr_ld_ext and wait_mem. Step 6 drives mdr_drv, ry_ld and done.
- R6: Opcode 7 is the indirect store. Step 4 drives ry_drv and mar_ld. Step 5 drives rx_drv and mdr_ld_int. Step 6 drives wr, wait_mem and done. rd and wr are never high together.
- R7: Opcode 9 is the unconditional branch. Step 4 drives imm_drv and z_ld, with alu_op = 1 and k4_sel low. Step 5 drives z_drv, pc_ld and done.
- R8: Opcodes 10, 11 and 12 are the branches on zero, on not-zero and on minus. Step 4 is as in R7, and in step 4 done is also high when the tested flag does not meet the condition. Otherwise the branch continues to step 5 as in R7.
- R9: Opcode 8 is the compare against an immediate. Step 4 drives imm_drv and y_ld. Step 5 drives ry_drv, alu_op = 2 (subtract) and done. ry_ld is never driven.
- R10: Opcode 4 is the register copy and opcode 5 is the immediate load. Each finishes in step 4, which drives rx_drv (opcode 4) or imm_drv (opcode 5), together with ry_ld and done.
- R11: Opcodes 13, 14 and 15 are increment, invert and shift left. Step 4 drives ry_drv and z_ld, with alu_op 5, 6 or 7. Step 5 drives z_drv, ry_ld and done.
- R12: When done is high and the counter is not held, the next cycle is step 1. When done is low and the counter is not held, the step advances by one.
- R13: In every step at most one of pc_drv, z_drv, mdr_drv, imm_drv, ry_drv and rx_drv is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | OP_W (4) | Opcode field of the instruction register |
| zf_i | input | 1 | Zero flag |
| nf_i | input | 1 | Minus flag |
| mem_done_i | input | 1 | Memory reports the current operation complete |
| pc_drv_o | output | 1 | PC onto the internal bus |
| mar_ld_o | output | 1 | Load the memory address register |
| rd_o | output | 1 | Memory read |
| wr_o | output | 1 | Memory write |
| k4_sel_o | output | 1 | ALU operand select: 1 = constant 4, 0 = Y |
| z_ld_o | output | 1 | Load the ALU result register Z |
| z_drv_o | output | 1 | Z onto the internal bus |
| pc_ld_o | output | 1 | Load PC |
| y_ld_o | output | 1 | Load Y |
| wait_mem_o | output | 1 | Wait for memory completion |
| mdr_ld_ext_o | output | 1 | Load the data register from the external data bus |
| mdr_ld_int_o | output | 1 | Load the data register from the internal bus |
| mdr_drv_o | output | 1 | Data register onto the internal bus |
| ir_ld_o | output | 1 | Load the instruction register |
| imm_drv_o | output | 1 | Instruction offset field onto the internal bus |
| ry_drv_o | output | 1 | Destination register onto the internal bus |
| rx_drv_o | output | 1 | Source register onto the internal bus |
| ry_ld_o | output | 1 | Load the destination register |
| alu_op_o | output | 3 | 0 idle, 1 add, 2 sub, 3 and, 4 or, 5 inc, 6 invert, 7 shift left |
| end_o | output | 1 | Last step of the instruction (done) |

## Verification
All control outputs are combinational functions of the step register, the opcode and the flags. They are therefore valid in the same cycle that these values are applied, and the step itself changes one clock edge later. The bench drives inputs at the falling edge and compares every output against its reference model 1 ns later. It then advances the model step according to what the rising edge will do: stall, restart at step 1, or increment. As a result, each comparison covers both the combinational decode in the current cycle and the counter update made one edge earlier. Memory completion is withheld for chosen numbers of cycles, so that both the fetch wait and the execute waits are held over several clocks.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_MOVR = 4'd4,
        OP_MOVI = 4'd5,
        OP_LDM  = 4'd6,
        OP_STM  = 4'd7,
        OP_CMP  = 4'd8,
        OP_BR   = 4'd9,
        OP_BRZ  = 4'd10,
        OP_BRNZ = 4'd11,
        OP_BRM  = 4'd12,
        OP_INC  = 4'd13,
        OP_INV  = 4'd14,
        OP_SHL  = 4'd15
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_IDLE = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_INC  = 3'd5,
        ALU_INV  = 3'd6,
        ALU_SHL  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    pc_drv;
        logic    mar_ld;
        logic    rd;
        logic    wr;
        logic    k4_sel;
        logic    z_ld;
        logic    z_drv;
        logic    pc_ld;
        logic    y_ld;
        logic    wait_mem;
        logic    mdr_ld_ext;
        logic    mdr_ld_int;
        logic    mdr_drv;
        logic    ir_ld;
        logic    imm_drv;
        logic    ry_drv;
        logic    rx_drv;
        logic    ry_ld;
        alu_op_e alu;
        logic    fin;
    } ctl_word_t;

    // ALU operation for the register-pair group, picked from one-hot opcode bits
    function automatic alu_op_e pair_alu(input logic is_add, input logic is_sub,
                                         input logic is_and, input logic is_or);
        alu_op_e r;
        r = ALU_IDLE;
        if (is_add) r = ALU_ADD;
        if (is_sub) r = ALU_SUB;
        if (is_and) r = ALU_AND;
        if (is_or)  r = ALU_OR;
        return r;
    endfunction

    // ALU operation for the single-register group
    function automatic alu_op_e unary_alu(input logic is_inc, input logic is_inv,
                                          input logic is_shl);
        alu_op_e r;
        r = ALU_IDLE;
        if (is_inc) r = ALU_INC;
        if (is_inv) r = ALU_INV;
        if (is_shl) r = ALU_SHL;
        return r;
    endfunction

endpackage

// File: rtl/ctl_onehot.sv
module ctl_onehot #(
    parameter int W = 4
) (
    input  logic [W-1:0]        code,
    output logic [(1<<W)-1:0]   hot
);
    localparam int N = 1 << W;

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign hot[i] = (code == W'(i));
    end
endmodule

// File: rtl/ctl_step_counter.sv
module ctl_step_counter #(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              fin,
    output logic [STEP_W-1:0] step_q
);
    localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= FIRST;
        end else if (!hold) begin
            if (fin) step_q <= FIRST;
            else     step_q <= step_q + STEP_W'(1);
        end
    end
endmodule

// File: rtl/ctl_signal_gen.sv
module ctl_signal_gen
    import ctl_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int OP_W   = 4
) (
    input  logic [(1<<STEP_W)-1:0] t,
    input  logic [(1<<OP_W)-1:0]   oh,
    input  logic                   zf,
    input  logic                   nf,
    output ctl_word_t              cw
);
    localparam int NSTEPS = 1 << STEP_W;

    logic binop, brall, unary, mv, cond_fail;
    logic unused_steps;

    assign unused_steps = ^{t[0], t[NSTEPS-1:7]};

    assign binop = oh[OP_ADD] | oh[OP_SUB] | oh[OP_AND] | oh[OP_OR];
    assign brall = oh[OP_BR] | oh[OP_BRZ] | oh[OP_BRNZ] | oh[OP_BRM];
    assign unary = oh[OP_INC] | oh[OP_INV] | oh[OP_SHL];
    assign mv    = oh[OP_MOVR] | oh[OP_MOVI];
    assign cond_fail = (oh[OP_BRZ] & ~zf) | (oh[OP_BRNZ] & zf) | (oh[OP_BRM] & ~nf);

    always_comb begin
        cw.pc_drv     = t[1];
        cw.mar_ld     = t[1] | (t[4] & (oh[OP_LDM] | oh[OP_STM]));
        cw.rd         = t[1] | (t[4] & oh[OP_LDM]);
        cw.wr         = t[6] & oh[OP_STM];
        cw.k4_sel     = t[1];
        cw.z_ld       = t[1] | (t[5] & binop) | (t[4] & (brall | unary));
        cw.z_drv      = t[2] | (t[6] & binop) | (t[5] & (brall | unary));
        cw.pc_ld      = t[2] | (t[5] & brall);
        cw.y_ld       = t[2] | (t[4] & (binop | oh[OP_CMP]));
        cw.wait_mem   = t[2] | (t[5] & oh[OP_LDM]) | (t[6] & oh[OP_STM]);
        cw.mdr_ld_ext = t[2] | (t[5] & oh[OP_LDM]);
        cw.mdr_ld_int = t[5] & oh[OP_STM];
        cw.mdr_drv    = t[3] | (t[6] & oh[OP_LDM]);
        cw.ir_ld      = t[3];
        cw.imm_drv    = t[4] & (brall | oh[OP_CMP] | oh[OP_MOVI]);
        cw.ry_drv     = (t[4] & (binop | oh[OP_STM] | unary)) | (t[5] & oh[OP_CMP]);
        cw.rx_drv     = (t[5] & (binop | oh[OP_STM])) | (t[4] & (oh[OP_LDM] | oh[OP_MOVR]));
        cw.ry_ld      = (t[6] & (binop | oh[OP_LDM])) | (t[4] & mv) | (t[5] & unary);
        cw.fin        = (t[6] & (binop | oh[OP_LDM] | oh[OP_STM]))
                      | (t[5] & (brall | oh[OP_CMP] | unary))
                      | (t[4] & (mv | cond_fail));

        cw.alu = ALU_IDLE;
        if (t[1] | (t[4] & brall))
            cw.alu = ALU_ADD;
        else if (t[5] & oh[OP_CMP])
            cw.alu = ALU_SUB;
        else if (t[5] & binop)
            cw.alu = pair_alu(oh[OP_ADD], oh[OP_SUB], oh[OP_AND], oh[OP_OR]);
        else if (t[4] & unary)
            cw.alu = unary_alu(oh[OP_INC], oh[OP_INV], oh[OP_SHL]);
    end
endmodule

// File: rtl/ctl_hardwired.sv
module ctl_hardwired
    import ctl_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int OP_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            zf_i,
    input  logic            nf_i,
    input  logic            mem_done_i,
    output logic            pc_drv_o,
    output logic            mar_ld_o,
    output logic            rd_o,
    output logic            wr_o,
    output logic            k4_sel_o,
    output logic            z_ld_o,
    output logic            z_drv_o,
    output logic            pc_ld_o,
    output logic            y_ld_o,
    output logic            wait_mem_o,
    output logic            mdr_ld_ext_o,
    output logic            mdr_ld_int_o,
    output logic            mdr_drv_o,
    output logic            ir_ld_o,
    output logic            imm_drv_o,
    output logic            ry_drv_o,
    output logic            rx_drv_o,
    output logic            ry_ld_o,
    output logic [2:0]      alu_op_o,
    output logic            end_o
);
    localparam int NSTEPS = 1 << STEP_W;
    localparam int NOPS   = 1 << OP_W;

    logic [STEP_W-1:0] step_q;
    logic [NSTEPS-1:0] t_hot;
    logic [NOPS-1:0]   op_hot;
    logic              hold;
    ctl_word_t         cw;

    assign hold = cw.wait_mem & ~mem_done_i;

    ctl_step_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .fin    (cw.fin),
        .step_q (step_q)
    );

    ctl_onehot #(.W(STEP_W)) u_tdec (.code(step_q),   .hot(t_hot));
    ctl_onehot #(.W(OP_W))   u_odec (.code(opcode_i), .hot(op_hot));

    ctl_signal_gen #(.STEP_W(STEP_W), .OP_W(OP_W)) u_gen (
        .t  (t_hot),
        .oh (op_hot),
        .zf (zf_i),
        .nf (nf_i),
        .cw (cw)
    );

    assign pc_drv_o     = cw.pc_drv;
    assign mar_ld_o     = cw.mar_ld;
    assign rd_o         = cw.rd;
    assign wr_o         = cw.wr;
    assign k4_sel_o     = cw.k4_sel;
    assign z_ld_o       = cw.z_ld;
    assign z_drv_o      = cw.z_drv;
    assign pc_ld_o      = cw.pc_ld;
    assign y_ld_o       = cw.y_ld;
    assign wait_mem_o   = cw.wait_mem;
    assign mdr_ld_ext_o = cw.mdr_ld_ext;
    assign mdr_ld_int_o = cw.mdr_ld_int;
    assign mdr_drv_o    = cw.mdr_drv;
    assign ir_ld_o      = cw.ir_ld;
    assign imm_drv_o    = cw.imm_drv;
    assign ry_drv_o     = cw.ry_drv;
    assign rx_drv_o     = cw.rx_drv;
    assign ry_ld_o      = cw.ry_ld;
    assign alu_op_o     = cw.alu;
    assign end_o        = cw.fin;
endmodule

// File: rtl/ctl_hardwired_chk.sv
module ctl_hardwired_chk #(
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [STEP_W-1:0] step,
    input logic              mem_done_i,
    input logic              wait_mem_o,
    input logic              end_o,
    input logic              rd_o,
    input logic              wr_o,
    input logic              pc_drv_o,
    input logic              z_drv_o,
    input logic              mdr_drv_o,
    input logic              imm_drv_o,
    input logic              ry_drv_o,
    input logic              rx_drv_o
);
    assert_reset_step_R1: assert property (@(posedge clk)
        rst |=> (step == STEP_W'(1)));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wait_mem_o && !mem_done_i) |=> $stable(step));

    assert_end_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (end_o && !(wait_mem_o && !mem_done_i)) |=> (step == STEP_W'(1)));

    assert_step_advance_R12: assert property (@(posedge clk) disable iff (rst)
        (!end_o && !(wait_mem_o && !mem_done_i)) |=> (step == $past(step) + STEP_W'(1)));

    assert_single_driver_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_drv_o, z_drv_o, mdr_drv_o, imm_drv_o, ry_drv_o, rx_drv_o}));

    assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(rd_o && wr_o));
endmodule

bind ctl_hardwired ctl_hardwired_chk #(.STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step       (step_q),
    .mem_done_i (mem_done_i),
    .wait_mem_o (wait_mem_o),
    .end_o      (end_o),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .pc_drv_o   (pc_drv_o),
    .z_drv_o    (z_drv_o),
    .mdr_drv_o  (mdr_drv_o),
    .imm_drv_o  (imm_drv_o),
    .ry_drv_o   (ry_drv_o),
    .rx_drv_o   (rx_drv_o)
);

// File: tb/tb_ctl_hardwired.sv
module tb_ctl_hardwired;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] opcode = 4'd0;
    logic zf = 1'b0, nf = 1'b0, mem_done = 1'b0;
    logic pc_drv_o, mar_ld_o, rd_o, wr_o, k4_sel_o, z_ld_o, z_drv_o, pc_ld_o, y_ld_o;
    logic wait_mem_o, mdr_ld_ext_o, mdr_ld_int_o, mdr_drv_o, ir_ld_o, imm_drv_o;
    logic ry_drv_o, rx_drv_o, ry_ld_o, end_o;
    logic [2:0] alu_op_o;

    always #10 clk = ~clk;

    ctl_hardwired dut (
        .clk(clk), .rst(rst), .opcode_i(opcode), .zf_i(zf), .nf_i(nf),
        .mem_done_i(mem_done),
        .pc_drv_o(pc_drv_o), .mar_ld_o(mar_ld_o), .rd_o(rd_o), .wr_o(wr_o),
        .k4_sel_o(k4_sel_o), .z_ld_o(z_ld_o), .z_drv_o(z_drv_o), .pc_ld_o(pc_ld_o),
        .y_ld_o(y_ld_o), .wait_mem_o(wait_mem_o), .mdr_ld_ext_o(mdr_ld_ext_o),
        .mdr_ld_int_o(mdr_ld_int_o), .mdr_drv_o(mdr_drv_o), .ir_ld_o(ir_ld_o),
        .imm_drv_o(imm_drv_o), .ry_drv_o(ry_drv_o), .rx_drv_o(rx_drv_o),
        .ry_ld_o(ry_ld_o), .alu_op_o(alu_op_o), .end_o(end_o)
    );

    // bench bit positions of the observed control vector
    localparam int P_PC = 0, P_MAR = 1, P_RD = 2, P_WR = 3, P_K4 = 4, P_ZLD = 5;
    localparam int P_ZDRV = 6, P_PCLD = 7, P_YLD = 8, P_WAIT = 9, P_MEXT = 10;
    localparam int P_MINT = 11, P_MDRV = 12, P_IR = 13, P_IMM = 14, P_RYD = 15;
    localparam int P_RXD = 16, P_RYLD = 17, P_END = 18;

    int errs = 0;
    int checks = 0;
    int m_step = 1;
    bit m_valid = 0;
    bit prev_rst = 0, prev_end = 0, prev_stall = 0;

    function automatic logic [21:0] expv(int s, int op, bit z, bit n);
        logic [21:0] v;
        bit take;
        v = '0;
        take = (op == 9) || (op == 10 && z) || (op == 11 && !z) || (op == 12 && n);
        if (s == 1) begin
            v[P_PC] = 1; v[P_MAR] = 1; v[P_RD] = 1; v[P_K4] = 1; v[P_ZLD] = 1;
            v[21:19] = 3'd1;
        end else if (s == 2) begin
            v[P_ZDRV] = 1; v[P_PCLD] = 1; v[P_YLD] = 1; v[P_WAIT] = 1; v[P_MEXT] = 1;
        end else if (s == 3) begin
            v[P_MDRV] = 1; v[P_IR] = 1;
        end else if (op <= 3) begin
            if (s == 4) begin v[P_RYD] = 1; v[P_YLD] = 1; end
            if (s == 5) begin v[P_RXD] = 1; v[P_ZLD] = 1; v[21:19] = 3'(op + 1); end
            if (s == 6) begin v[P_ZDRV] = 1; v[P_RYLD] = 1; v[P_END] = 1; end
        end else if (op == 4 || op == 5) begin
            if (s == 4) begin
                if (op == 4) v[P_RXD] = 1; else v[P_IMM] = 1;
                v[P_RYLD] = 1; v[P_END] = 1;
            end
        end else if (op == 6) begin
            if (s == 4) begin v[P_RXD] = 1; v[P_MAR] = 1; v[P_RD] = 1; end
            if (s == 5) begin v[P_MEXT] = 1; v[P_WAIT] = 1; end
            if (s == 6) begin v[P_MDRV] = 1; v[P_RYLD] = 1; v[P_END] = 1; end
        end else if (op == 7) begin
            if (s == 4) begin v[P_RYD] = 1; v[P_MAR] = 1; end
            if (s == 5) begin v[P_RXD] = 1; v[P_MINT] = 1; end
            if (s == 6) begin v[P_WR] = 1; v[P_WAIT] = 1; v[P_END] = 1; end
        end else if (op == 8) begin
            if (s == 4) begin v[P_IMM] = 1; v[P_YLD] = 1; end
            if (s == 5) begin v[P_RYD] = 1; v[21:19] = 3'd2; v[P_END] = 1; end
        end else if (op <= 12) begin
            if (s == 4) begin
                v[P_IMM] = 1; v[P_ZLD] = 1; v[21:19] = 3'd1; v[P_END] = !take;
            end
            if (s == 5) begin v[P_ZDRV] = 1; v[P_PCLD] = 1; v[P_END] = 1; end
        end else begin
            if (s == 4) begin v[P_RYD] = 1; v[P_ZLD] = 1; v[21:19] = 3'(op - 8); end
            if (s == 5) begin v[P_ZDRV] = 1; v[P_RYLD] = 1; v[P_END] = 1; end
        end
        return v;
    endfunction

    task automatic cycle(input bit r, input int op, input bit z, input bit n,
                         input bit mfc, input string tag);
        logic [21:0] act, e;
        string t;
        bit stall;
        @(negedge clk);
        rst = r; opcode = 4'(op); zf = z; nf = n; mem_done = mfc;
        #1;
        act = {alu_op_o, end_o, ry_ld_o, rx_drv_o, ry_drv_o, imm_drv_o, ir_ld_o,
               mdr_drv_o, mdr_ld_int_o, mdr_ld_ext_o, wait_mem_o, y_ld_o, pc_ld_o,
               z_drv_o, z_ld_o, k4_sel_o, wr_o, rd_o, mar_ld_o, pc_drv_o};
        e = expv(m_step, op, z, n);
        stall = e[P_WAIT] && !mfc;
        if (m_valid) begin
            t = tag;
            if (m_step <= 3) t = "R2";
            if (prev_end && m_step == 1) t = "R12";
            if (prev_stall) t = "R3";
            if (prev_rst) t = "R1";
            checks++;
            if (act !== e) begin
                errs++;
                $display("FAIL %s step=%0d op=%0d actual=%h expected=%h", t, m_step, op, act, e);
            end
            checks++;
            if ($countones({pc_drv_o, z_drv_o, mdr_drv_o, imm_drv_o, ry_drv_o, rx_drv_o}) > 1) begin
                errs++;
                $display("FAIL R13 bus drivers actual=%0d expected<=1",
                    $countones({pc_drv_o, z_drv_o, mdr_drv_o, imm_drv_o, ry_drv_o, rx_drv_o}));
            end
        end
        prev_rst = r;
        prev_end = e[P_END] && !stall && !r;
        prev_stall = stall && !r;
        if (r) begin
            m_step = 1; m_valid = 1;
        end else if (!stall) begin
            m_step = e[P_END] ? 1 : m_step + 1;
        end
    endtask

    task automatic run_instr(input int op, input bit z, input bit n, input int delay,
                             input string tag);
        int waited;
        bit fin;
        bit wm, mfc, st;
        logic [21:0] e;
        waited = 0;
        fin = 0;
        while (!fin) begin
            e = expv(m_step, op, z, n);
            wm = e[P_WAIT];
            mfc = wm && (waited >= delay);
            st = wm && !mfc;
            waited = st ? waited + 1 : 0;
            fin = e[P_END] && !st;
            cycle(0, op, z, n, mfc, tag);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        cycle(1, 0, 0, 0, 0, "R1");
        cycle(1, 0, 0, 0, 0, "R1");
        run_instr(0,  0, 0, 0, "R4");
        run_instr(1,  0, 0, 2, "R4");
        run_instr(2,  1, 1, 1, "R4");
        run_instr(3,  0, 0, 0, "R4");
        run_instr(4,  0, 0, 0, "R10");
        run_instr(5,  1, 0, 3, "R10");
        run_instr(6,  0, 0, 3, "R5");
        run_instr(6,  0, 0, 0, "R5");
        run_instr(7,  0, 0, 2, "R6");
        run_instr(7,  1, 1, 0, "R6");
        run_instr(8,  0, 0, 1, "R9");
        run_instr(9,  0, 0, 0, "R7");
        run_instr(10, 1, 0, 0, "R8");
        run_instr(10, 0, 1, 0, "R8");
        run_instr(11, 0, 0, 0, "R8");
        run_instr(11, 1, 0, 0, "R8");
        run_instr(12, 0, 1, 0, "R8");
        run_instr(12, 1, 0, 1, "R8");
        run_instr(13, 0, 0, 0, "R11");
        run_instr(14, 0, 0, 2, "R11");
        run_instr(15, 1, 1, 0, "R11");
        // reset in the middle of an instruction returns to the fetch (R1)
        cycle(0, 0, 0, 0, 1, "R4");
        cycle(0, 0, 0, 0, 1, "R4");
        cycle(0, 0, 0, 0, 1, "R4");
        cycle(1, 0, 0, 0, 0, "R1");
        run_instr(3, 0, 0, 1, "R4");
        for (int k = 0; k < 16; k++) run_instr(k, k[0], k[1], k % 3, "R12");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule